// File: doc/BRIEF.md
# Serial NOR Flash Identification Sequencer

This block reads a fixed set of identity and status values out of a serial NOR flash without any processor involvement. A one-cycle start pulse launches five queries, always in the same order. Each query runs in its own chip-select frame. The sequencer sends an opcode, then any zero-valued address or dummy bytes the query needs, and drops whatever the flash returns during that phase. It then clocks out zero bytes to gather the reply. When the last reply byte of the last query is in, chip select goes high and a done pulse follows.

Each byte is exchanged by an internal byte-wide SPI shifter in mode 0. The clock idles low, data is shifted most significant bit first, MOSI changes after a falling edge and MISO is sampled on a rising edge. The control side never starts a byte while the shifter is busy. It only moves on once the shifter reports a completed byte. The results sit in output registers that hold their value until a later run overwrites them.

Top module: `flash_id_sequencer`

## Requirements
- R1: While reset is low and right after it, csN is 1, sclk is 0, done is 0 and every result output is zero; a reset in the middle of a run ends the run at once.
- R2: A run carries out exactly five chip-select frames in this order of first byte: 0x90, 0x9F, 0x4B, 0x05, 0x35.
- R3: Frame lengths in bytes are 6 (0x90, three 0x00 address bytes, 2 reply bytes), 4 (0x9F, 3 reply bytes), 13 (0x4B, four 0x00 dummy bytes, 8 reply bytes), 2 (0x05, 1 reply byte) and 2 (0x35, 1 reply byte); every byte after the opcode in the command phase is 0x00.
- R4: Every byte sent during a reply phase is 0x00.
- R5: Bytes received during a command phase are discarded. Reply bytes are packed with the first received byte most significant: manDevId holds the 2 bytes of frame 1, jedecId the 3 bytes of frame 2, uniqueId the 8 bytes of frame 3, status1 the byte of frame 4 and status2 the byte of frame 5.
- R6: SPI mode 0: sclk is low whenever no byte is being shifted; each sclk half period lasts HALF_DIV clk cycles; MOSI is sent MSB first and MISO is sampled on the rising sclk edge.
- R7: csN stays low for the whole of a frame and stays high for at least 2*HALF_DIV*GAP_SCLK clk cycles (GAP_SCLK sclk periods) before each frame starts.
- R8: done is a single-cycle pulse in the cycle after csN rises at the end of frame 5, and the result outputs are already valid in that cycle.
- R9: A start pulse that arrives while a run is in progress has no effect: the run still produces exactly five frames and one done pulse, and no new run follows.
- R10: A new byte exchange starts only when the shifter is idle, so every frame consists of whole 8-bit bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that launches a run when the sequencer is idle |
| miso | input | 1 | Serial data from the flash |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the flash |
| csN | output | 1 | Active-low chip select |
| done | output | 1 | One-cycle pulse at the end of a run |
| manDevId | output | 16 | Manufacturer and device ID reply |
| jedecId | output | 24 | Three-byte identity reply |
| uniqueId | output | 64 | Eight-byte unique ID reply |
| status1 | output | 8 | First status register reply |
| status2 | output | 8 | Second status register reply |

## Verification
Faults show up at the ports within one frame:
- A wrong query or byte index in the control makes a frame carry the wrong opcode, the wrong length, or a non-zero byte where a zero belongs. The flash model on the bench records each of these as soon as that frame closes.
- A wrong store offset or a command byte that is kept instead of dropped shows up as a mismatched result field at the done pulse. The bench makes the junk bytes on MISO distinct from the reply bytes so that such a mix-up cannot pass.
- A fault in sequencing shows up as a short chip-select gap, a partial byte, a missing or stretched done pulse, or an extra run after a start pulse that should have been ignored. The bench flags each of these in the cycle or frame where it happens.

// File: rtl/flash_id_pkg.sv
package flash_id_pkg;

  localparam int NUM_QUERIES = 5;
  localparam int RSP_BYTES   = 15;

  typedef struct packed {
    logic startXfer;
    logic storeRx;
  } seqStrobe_t;

  function automatic logic [7:0] qOpcode(input logic [2:0] q);
    case (q)
      3'd0:    return 8'h90;
      3'd1:    return 8'h9F;
      3'd2:    return 8'h4B;
      3'd3:    return 8'h05;
      default: return 8'h35;
    endcase
  endfunction

  function automatic logic [3:0] qCmdLen(input logic [2:0] q);
    case (q)
      3'd0:    return 4'd4;
      3'd2:    return 4'd5;
      default: return 4'd1;
    endcase
  endfunction

  function automatic logic [3:0] qRspLen(input logic [2:0] q);
    case (q)
      3'd0:    return 4'd2;
      3'd1:    return 4'd3;
      3'd2:    return 4'd8;
      default: return 4'd1;
    endcase
  endfunction

  function automatic logic [3:0] qRspBase(input logic [2:0] q);
    case (q)
      3'd0:    return 4'd0;
      3'd1:    return 4'd2;
      3'd2:    return 4'd5;
      3'd3:    return 4'd13;
      default: return 4'd14;
    endcase
  endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startXfer,
  input  logic [7:0] txByte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       rxDone,
  output logic [7:0] rxByte
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0] divCnt;
  logic [2:0]    bitCnt;
  logic [7:0]    txReg;
  logic [7:0]    rxReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      sclk   <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
      txReg  <= '0;
      rxReg  <= '0;
      rxDone <= 1'b0;
    end else begin
      rxDone <= 1'b0;
      if (startXfer && !busy) begin
        busy   <= 1'b1;
        sclk   <= 1'b0;
        divCnt <= '0;
        bitCnt <= '0;
        txReg  <= txByte;
      end else if (busy) begin
        if (divCnt == DW'(HALF_DIV - 1)) begin
          divCnt <= '0;
          if (!sclk) begin
            sclk  <= 1'b1;
            rxReg <= {rxReg[6:0], miso};
          end else begin
            sclk  <= 1'b0;
            txReg <= {txReg[6:0], 1'b0};
            if (bitCnt == 3'd7) begin
              busy   <= 1'b0;
              rxDone <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 3'd1;
            end
          end
        end else begin
          divCnt <= divCnt + DW'(1);
        end
      end
    end
  end

  assign mosi   = txReg[7];
  assign rxByte = rxReg;

  // R6
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclk);

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    startXfer |-> !busy);

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import flash_id_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  seqStrobe_t  strobe,
  input  logic [7:0]  txByte,
  input  logic [3:0]  storeIdx,
  input  logic        miso,
  output logic        sclk,
  output logic        mosi,
  output logic        shBusy,
  output logic        rxDone,
  output logic [15:0] manDevId,
  output logic [23:0] jedecId,
  output logic [63:0] uniqueId,
  output logic [7:0]  status1,
  output logic [7:0]  status2
);
  logic [7:0] rxByte;
  logic [7:0] rspMem [RSP_BYTES];

  spi_byte_shifter #(.HALF_DIV(HALF_DIV)) uShift (
    .clk(clk), .rstN(rstN), .startXfer(strobe.startXfer), .txByte(txByte),
    .miso(miso), .sclk(sclk), .mosi(mosi), .busy(shBusy),
    .rxDone(rxDone), .rxByte(rxByte)
  );

  for (genvar g = 0; g < RSP_BYTES; g++) begin : gRsp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        rspMem[g] <= '0;
      else if (strobe.storeRx && storeIdx == 4'(g))
        rspMem[g] <= rxByte;
    end
  end

  assign manDevId = {rspMem[0], rspMem[1]};
  assign jedecId  = {rspMem[2], rspMem[3], rspMem[4]};
  assign uniqueId = {rspMem[5], rspMem[6], rspMem[7], rspMem[8],
                     rspMem[9], rspMem[10], rspMem[11], rspMem[12]};
  assign status1  = rspMem[13];
  assign status2  = rspMem[14];

  // R5
  store_on_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeRx |-> rxDone);

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import flash_id_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int GAP_SCLK = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       shBusy,
  input  logic       rxDone,
  output seqStrobe_t strobe,
  output logic [7:0] txByte,
  output logic [3:0] storeIdx,
  output logic       csN,
  output logic       done
);
  localparam int GAP_CYC = 2 * HALF_DIV * GAP_SCLK;
  localparam int GW      = $clog2(GAP_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_ISSUE, S_WAIT, S_FIN} seqState_t;

  seqState_t      state;
  logic [2:0]     qIdx;
  logic [3:0]     byteIdx;
  logic [GW-1:0]  gapCnt;
  logic [3:0]     cmdLen;
  logic [3:0]     lastIdx;
  logic           inRsp;

  always_comb begin
    cmdLen   = qCmdLen(qIdx);
    lastIdx  = 4'(cmdLen + qRspLen(qIdx) - 4'd1);
    inRsp    = byteIdx >= cmdLen;
    txByte   = (byteIdx == 4'd0) ? qOpcode(qIdx) : 8'h00;
    storeIdx = 4'(qRspBase(qIdx) + byteIdx - cmdLen);
    strobe.startXfer = (state == S_ISSUE) && !shBusy;
    strobe.storeRx   = (state == S_WAIT) && rxDone && inRsp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      qIdx    <= '0;
      byteIdx <= '0;
      gapCnt  <= '0;
      csN     <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          qIdx   <= '0;
          gapCnt <= '0;
          state  <= S_GAP;
        end
        S_GAP: begin
          if (gapCnt == GW'(GAP_CYC - 1)) begin
            csN     <= 1'b0;
            byteIdx <= '0;
            state   <= S_ISSUE;
          end else begin
            gapCnt <= gapCnt + GW'(1);
          end
        end
        S_ISSUE: if (!shBusy) state <= S_WAIT;
        S_WAIT: if (rxDone) begin
          if (byteIdx == lastIdx) begin
            csN    <= 1'b1;
            gapCnt <= '0;
            if (qIdx == 3'(NUM_QUERIES - 1)) begin
              state <= S_FIN;
            end else begin
              qIdx  <= qIdx + 3'd1;
              state <= S_GAP;
            end
          end else begin
            byteIdx <= byteIdx + 4'd1;
            state   <= S_ISSUE;
          end
        end
        S_FIN: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7
  cs_low_while_shifting_chk: assert property (@(posedge clk) disable iff (!rstN)
    shBusy |-> !csN);

  // R8
  done_after_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (csN && $past(csN)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/flash_id_sequencer.sv
module flash_id_sequencer
  import flash_id_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int GAP_SCLK = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        miso,
  output logic        sclk,
  output logic        mosi,
  output logic        csN,
  output logic        done,
  output logic [15:0] manDevId,
  output logic [23:0] jedecId,
  output logic [63:0] uniqueId,
  output logic [7:0]  status1,
  output logic [7:0]  status2
);
  seqStrobe_t strobe;
  logic [7:0] txByte;
  logic [3:0] storeIdx;
  logic       shBusy;
  logic       rxDone;

  seq_ctrl #(.HALF_DIV(HALF_DIV), .GAP_SCLK(GAP_SCLK)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .shBusy(shBusy), .rxDone(rxDone),
    .strobe(strobe), .txByte(txByte), .storeIdx(storeIdx),
    .csN(csN), .done(done)
  );

  seq_datapath #(.HALF_DIV(HALF_DIV)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txByte(txByte),
    .storeIdx(storeIdx), .miso(miso), .sclk(sclk), .mosi(mosi),
    .shBusy(shBusy), .rxDone(rxDone), .manDevId(manDevId),
    .jedecId(jedecId), .uniqueId(uniqueId), .status1(status1),
    .status2(status2)
  );

endmodule

// File: tb/sim_flash_id_sequencer.sv
module sim_flash_id_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_DIV   = 2;
  localparam int GAP_SCLK   = 2;
  localparam int GAP_CYC    = 2 * HALF_DIV * GAP_SCLK;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, miso = 1'b0;
  logic sclk, mosi, csN, done;
  logic [15:0] manDevId;
  logic [23:0] jedecId;
  logic [63:0] uniqueId;
  logic [7:0]  status1, status2;

  int checks = 0, fails = 0;

  flash_id_sequencer #(.HALF_DIV(HALF_DIV), .GAP_SCLK(GAP_SCLK)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .miso(miso), .sclk(sclk),
    .mosi(mosi), .csN(csN), .done(done), .manDevId(manDevId),
    .jedecId(jedecId), .uniqueId(uniqueId), .status1(status1),
    .status2(status2)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- expected-value functions ----------------
  function automatic logic [7:0] expOp(input int q);
    case (q)
      0: return 8'h90; 1: return 8'h9F; 2: return 8'h4B;
      3: return 8'h05; default: return 8'h35;
    endcase
  endfunction
  function automatic int expCmdLen(input int q);
    case (q) 0: return 4; 2: return 5; default: return 1; endcase
  endfunction
  function automatic int expRspLen(input int q);
    case (q) 0: return 2; 1: return 3; 2: return 8; default: return 1; endcase
  endfunction
  function automatic int qOfOp(input logic [7:0] op);
    for (int q = 0; q < 5; q++) if (expOp(q) == op) return q;
    return -1;
  endfunction

  // ---------------- flash model ----------------
  logic [7:0] rspVal [5][8];
  logic [7:0] junk;
  logic [7:0] frm [8][16];
  int frmLen [8];
  int frameNo = 0, mBit = 0, mByte = 0;
  logic [7:0] mIn = 0, mOut = 0;
  int partialBytes = 0, gapViol = 0, idleViol = 0, doneCnt = 0, doneWide = 0;
  time tRise = 0;
  logic prevDone = 1'b0;

  function automatic logic [7:0] nextOut();
    int fi, q, cl;
    fi = frameNo - 1;
    if (mByte == 0 || fi < 0 || fi > 7) return junk;
    q = qOfOp(frm[fi][0]);
    if (q < 0) return junk;
    cl = expCmdLen(q);
    if (mByte < cl || mByte - cl > 7) return junk;
    return rspVal[q][mByte - cl];
  endfunction

  always @(negedge csN) begin
    if (rstN === 1'b1 && tRise != 0 && ($time - tRise) < GAP_CYC * CLK_PERIOD)
      gapViol++;
    frameNo++;
    mBit = 0; mByte = 0;
    mOut = nextOut();
    miso = mOut[7];
  end

  always @(posedge csN) begin
    tRise = $time;
    if (rstN === 1'b1 && mBit != 0) partialBytes++;
  end

  always @(posedge sclk) if (csN === 1'b0) begin
    mIn = {mIn[6:0], mosi};
    mBit++;
    if (mBit == 8) begin
      if (frameNo >= 1 && frameNo <= 8 && mByte < 16) begin
        frm[frameNo-1][mByte] = mIn;
        frmLen[frameNo-1] = mByte + 1;
      end
      mByte++;
      mBit = 0;
    end
  end

  always @(negedge sclk) if (csN === 1'b0) begin
    if (mBit == 0) mOut = nextOut();
    miso = mOut[7 - mBit];
  end

  always @(negedge clk) if (rstN) begin
    if (csN === 1'b1 && sclk !== 1'b0) idleViol++;
    if (done === 1'b1) begin
      doneCnt++;
      if (csN !== 1'b1) doneWide++;
    end
    if (done === 1'b1 && prevDone === 1'b1) doneWide++;
    prevDone = done;
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clearRecord();
    frameNo = 0;
    doneCnt = 0; doneWide = 0; gapViol = 0; idleViol = 0; partialBytes = 0;
    for (int f = 0; f < 8; f++) begin
      frmLen[f] = 0;
      for (int b = 0; b < 16; b++) frm[f][b] = 8'hXX;
    end
  endtask

  task automatic waitDone(output bit seen);
    seen = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done === 1'b1) begin seen = 1; break; end
    end
  endtask

  task automatic runSeq(input bit midStart);
    bit seen;
    logic [63:0] expUid;
    clearRecord();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (midStart) begin
      repeat (300) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      repeat (150) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    waitDone(seen);
    chk(seen, "R8", "done pulse seen", 64'(seen), 64'd1);
    // R5 results valid in the done cycle
    chk(manDevId == {rspVal[0][0], rspVal[0][1]}, "R5", "manDevId",
        64'(manDevId), 64'({rspVal[0][0], rspVal[0][1]}));
    chk(jedecId == {rspVal[1][0], rspVal[1][1], rspVal[1][2]}, "R5", "jedecId",
        64'(jedecId), 64'({rspVal[1][0], rspVal[1][1], rspVal[1][2]}));
    expUid = '0;
    for (int k = 0; k < 8; k++) expUid = {expUid[55:0], rspVal[2][k]};
    chk(uniqueId == expUid, "R5", "uniqueId", uniqueId, expUid);
    chk(status1 == rspVal[3][0], "R5", "status1", 64'(status1), 64'(rspVal[3][0]));
    chk(status2 == rspVal[4][0], "R5", "status2", 64'(status2), 64'(rspVal[4][0]));
    repeat (400) @(negedge clk);
    // R9 no extra run, single done
    chk(frameNo == 5, "R9", "frame count after run", 64'(frameNo), 64'd5);
    chk(doneCnt == 1, "R9", "done pulses", 64'(doneCnt), 64'd1);
    chk(doneWide == 0, "R8", "done width or csN at done", 64'(doneWide), 64'd0);
    for (int f = 0; f < 5; f++) begin
      int q;
      q = f;
      // R2 order of opcodes
      chk(frm[f][0] === expOp(q), "R2", "frame opcode", 64'(frm[f][0]), 64'(expOp(q)));
      // R3 frame length
      chk(frmLen[f] == expCmdLen(q) + expRspLen(q), "R3", "frame length",
          64'(frmLen[f]), 64'(expCmdLen(q) + expRspLen(q)));
      for (int b = 1; b < expCmdLen(q); b++)
        chk(frm[f][b] === 8'h00, "R3", "address/dummy byte", 64'(frm[f][b]), 64'd0);
      for (int b = expCmdLen(q); b < expCmdLen(q) + expRspLen(q); b++)
        chk(frm[f][b] === 8'h00, "R4", "reply-phase mosi byte", 64'(frm[f][b]), 64'd0);
    end
    chk(gapViol == 0, "R7", "short csN gaps", 64'(gapViol), 64'd0);
    chk(idleViol == 0, "R6", "sclk high while idle", 64'(idleViol), 64'd0);
    chk(partialBytes == 0, "R10", "frames with partial bytes", 64'(partialBytes), 64'd0);
  endtask

  task automatic fillRsp(input int mode);
    for (int q = 0; q < 5; q++)
      for (int k = 0; k < 8; k++)
        case (mode)
          0: rspVal[q][k] = 8'hFF;
          1: rspVal[q][k] = 8'h00;
          default: rspVal[q][k] = 8'($urandom);
        endcase
    case (mode)
      0: junk = 8'h00;
      1: junk = 8'hFF;
      default: begin
        junk = 8'($urandom);
        if (junk == rspVal[0][0]) junk = ~junk;
      end
    endcase
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    bit seen;
    void'($urandom(32'd1234));
    fillRsp(2);
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(csN === 1'b1, "R1", "csN in reset", 64'(csN), 64'd1);
    chk(sclk === 1'b0, "R1", "sclk in reset", 64'(sclk), 64'd0);
    chk(done === 1'b0, "R1", "done in reset", 64'(done), 64'd0);
    chk(uniqueId === 64'd0 && manDevId === 16'd0, "R1", "results in reset",
        uniqueId, 64'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // directed extremes: replies all ones with zero junk, and the reverse
    fillRsp(0); runSeq(0);
    fillRsp(1); runSeq(0);

    // random runs, some with ignored start pulses
    for (int r = 0; r < 5; r++) begin
      fillRsp(2);
      runSeq(r % 2 == 1);
    end

    // R1 reset in the middle of a run
    fillRsp(2);
    clearRecord();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (350) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk(csN === 1'b1, "R1", "csN after mid-run reset", 64'(csN), 64'd1);
    chk(sclk === 1'b0, "R1", "sclk after mid-run reset", 64'(sclk), 64'd0);
    chk(manDevId === 16'd0, "R1", "manDevId after mid-run reset", 64'(manDevId), 64'd0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (400) @(negedge clk);
    chk(csN === 1'b1 && doneCnt == 0, "R1", "idle after reset without start",
        64'(doneCnt), 64'd0);
    runSeq(0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule